// File: doc/BRIEF.md
# Object Handle Hash Table Engine

This block keeps a per-channel lookup table in its own on-chip RAM that maps 32-bit object handles to 32-bit context words. A client issues one operation at a time (lookup, insert or remove) along with a handle, a channel id, a mode flag and, for insert, the context word. The engine then walks the table and reports an outcome: success, not-found or table-full. A lookup that hits also returns the stored context word.

The home slot comes from an XOR fold of the handle in chunks as wide as the slot index. In legacy mode the fold also takes in the channel id. Collisions are resolved by open addressing: the probe steps one entry (8 bytes) at a time and wraps from the last entry back to entry zero. What counts as an occupied entry depends on the mode. In legacy mode an entry is occupied when bit 31 of its context word is set. In the newer mode it is occupied when the context word is non-zero. After reset the engine clears its whole table before it accepts any work.

Top module: `obj_hash_engine`

## Requirements
- R1: After reset is released, `busy` stays high for exactly 2^SLOT_BITS cycles while every entry is cleared to zero. After that, any lookup reports not-found.
- R2: The home slot is the XOR of all SLOT_BITS-wide chunks of the handle, taken from bit 0 upward with zero padding at the top. When `legacy_mode` is 1, `chan << (SLOT_BITS-4)` is also XORed in. When `legacy_mode` is 0, the channel does not affect the home slot.
- R3: Insert (`op`=1) writes the handle and context word into the first unoccupied entry found by probing upward from the home slot. The probe wraps from the last entry to entry 0.
- R4: In legacy mode an entry is occupied when bit 31 of its context word is 1. In the newer mode it is occupied when the context word is non-zero. An entry that is not occupied in the current mode may be overwritten by insert.
- R5: Lookup (`op`=0) probes from the home slot. On the first occupied entry whose handle matches, it returns that entry's context word on `ctx_out` with `status`=0. After a full wrap with no match it reports `status`=1 (not-found) and `ctx_out`=0.
- R6: Remove (`op`=2) zeroes both words of the first occupied entry whose handle matches and reports `status`=0. If no entry matches after a full wrap, it reports `status`=1 and changes nothing.
- R7: An insert that wraps back to its home slot without finding an unoccupied entry reports `status`=2 (table-full) and writes nothing.
- R8: A `start` pulse in idle is accepted on that clock edge and `busy` rises. Each probe takes two cycles, so `done` pulses for one cycle exactly 2·k edges after acceptance, where k is the number of entries probed, and `busy` is low in that same cycle. A `start` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request an operation (accepted only when idle) |
| op | input | 2 | 0 lookup, 1 insert, 2 remove |
| legacy_mode | input | 1 | 1 selects legacy hashing and occupancy test |
| handle | input | 32 | Object handle |
| chan | input | CHAN_W | Channel id |
| ctx_in | input | 32 | Context word to store on insert |
| busy | output | 1 | Clearing or operation in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 not-found, 2 table-full |
| ctx_out | output | 32 | Context word found by a lookup hit, else 0 |

## Verification
The hardest case to reach is a probe that runs off the last entry and continues at entry 0. It is also hard to reach the full-wrap outcomes, which only appear once every slot is occupied or none matches. The stimulus builds a handle whose fold lands on the top slot, plus a second handle that folds to the same slot, so the second insert wraps. It then fills all entries and issues one more insert and a missing lookup. Latency is compared against the model's probe count for every operation, which exposes off-by-one errors in the wrap and in the home-slot return.

// File: rtl/obj_hash_pkg.sv
// Package: shared operation and status codes for the handle hash engine.
// Assumes: codes are fixed by the external interface.
package obj_hash_pkg;
    typedef enum logic [1:0] {
        OP_LOOKUP = 2'd0,
        OP_INSERT = 2'd1,
        OP_REMOVE = 2'd2
    } op_e;

    localparam logic [1:0] ST_OK   = 2'd0;
    localparam logic [1:0] ST_MISS = 2'd1;
    localparam logic [1:0] ST_FULL = 2'd2;
endpackage

// File: rtl/obj_hash_fold.sv
// Module: obj_hash_fold
// Computes the home slot index of a handle by XOR-folding SLOT_BITS-wide
// chunks, optionally mixing in the channel id (legacy mode).
// Assumes: SLOT_BITS >= 4 and CHAN_W + SLOT_BITS - 4 <= SLOT_BITS.
module obj_hash_fold #(
    parameter int SLOT_BITS = 6,
    parameter int CHAN_W    = 4
) (
    input  logic [31:0]          handle,
    input  logic [CHAN_W-1:0]    chan,
    input  logic                 legacy,
    output logic [SLOT_BITS-1:0] slot
);
    localparam int NCHUNK = (32 + SLOT_BITS - 1) / SLOT_BITS;
    localparam int PADW   = NCHUNK * SLOT_BITS;

    logic [PADW-1:0]      padded;
    logic [SLOT_BITS-1:0] part [NCHUNK+1];
    logic [SLOT_BITS-1:0] chan_mix;

    assign padded  = PADW'(handle);
    assign part[0] = '0;

    // Chained XOR of successive chunks from the low end upward.
    for (genvar k = 0; k < NCHUNK; k++) begin : g_chunk
        assign part[k+1] = part[k] ^ padded[k*SLOT_BITS +: SLOT_BITS];
    end

    // Channel term, present only in legacy mode.
    always_comb begin
        chan_mix = SLOT_BITS'(32'(chan) << (SLOT_BITS - 4));
        slot     = part[NCHUNK] ^ (legacy ? chan_mix : '0);
    end
endmodule

// File: rtl/obj_hash_ram.sv
// Module: obj_hash_ram
// Simple dual-port table storage: one write port, one read port with a
// single cycle of synchronous read latency. Each word is one entry,
// {handle, context}. No reset; the controller clears it.
module obj_hash_ram #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Write port.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/obj_hash_ctrl.sv
// Module: obj_hash_ctrl
// Sequencer: clears the table after reset, then runs one operation at a
// time with a wrapping linear probe (two cycles per probed entry).
// Assumes: home_slot is computed combinationally from the request ports.
module obj_hash_ctrl
    import obj_hash_pkg::*;
#(
    parameter int SLOT_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [1:0]           op,
    input  logic                 legacy_mode,
    input  logic [31:0]          handle,
    input  logic [31:0]          ctx_in,
    input  logic [SLOT_BITS-1:0] home_slot,
    output logic                 ram_we,
    output logic [SLOT_BITS-1:0] ram_waddr,
    output logic [63:0]          ram_wdata,
    output logic                 ram_re,
    output logic [SLOT_BITS-1:0] ram_raddr,
    input  logic [63:0]          ram_rdata,
    output logic                 busy,
    output logic                 done,
    output logic [1:0]           status,
    output logic [31:0]          ctx_out
);
    localparam logic [SLOT_BITS-1:0] LAST = '1;

    typedef enum logic [1:0] {S_CLEAR, S_IDLE, S_READ, S_EVAL} state_e;

    state_e               state;
    logic [SLOT_BITS-1:0] clr_idx;
    logic [SLOT_BITS-1:0] home_q;
    logic [SLOT_BITS-1:0] probe_q;
    logic [SLOT_BITS-1:0] probe_nx;
    op_e                  req_op;
    logic [31:0]          req_handle;
    logic [31:0]          req_ctx;
    logic                 req_legacy;
    logic [31:0]          rd_handle;
    logic [31:0]          rd_ctx;
    logic                 occupied;
    logic                 match;
    logic                 hit;

    // Decode the entry just read and decide whether the probe ends here.
    always_comb begin
        rd_handle = ram_rdata[63:32];
        rd_ctx    = ram_rdata[31:0];
        occupied  = req_legacy ? rd_ctx[31] : (rd_ctx != 32'd0);
        match     = occupied && (rd_handle == req_handle);
        hit       = (req_op == OP_INSERT) ? !occupied : match;
        probe_nx  = probe_q + SLOT_BITS'(1);
    end

    // Table port drive: clearing sweep, or insert/remove write on a hit.
    always_comb begin
        ram_re    = (state == S_READ);
        ram_raddr = probe_q;
        ram_we    = (state == S_CLEAR) ||
                    (state == S_EVAL && hit && req_op != OP_LOOKUP);
        ram_waddr = (state == S_CLEAR) ? clr_idx : probe_q;
        ram_wdata = (state == S_EVAL && req_op == OP_INSERT) ?
                    {req_handle, req_ctx} : 64'd0;
    end

    assign busy = (state != S_IDLE);

    // Main sequencer: clear, accept, probe, complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_CLEAR;
            clr_idx    <= '0;
            home_q     <= '0;
            probe_q    <= '0;
            req_op     <= OP_LOOKUP;
            req_handle <= '0;
            req_ctx    <= '0;
            req_legacy <= 1'b0;
            done       <= 1'b0;
            status     <= ST_OK;
            ctx_out    <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                S_CLEAR: begin
                    clr_idx <= clr_idx + SLOT_BITS'(1);
                    if (clr_idx == LAST) state <= S_IDLE;
                end
                S_IDLE: begin
                    if (start) begin
                        req_op     <= op_e'(op);
                        req_handle <= handle;
                        req_ctx    <= ctx_in;
                        req_legacy <= legacy_mode;
                        home_q     <= home_slot;
                        probe_q    <= home_slot;
                        state      <= S_READ;
                    end
                end
                S_READ: state <= S_EVAL;
                S_EVAL: begin
                    if (hit) begin
                        done    <= 1'b1;
                        status  <= ST_OK;
                        ctx_out <= (req_op == OP_LOOKUP) ? rd_ctx : 32'd0;
                        state   <= S_IDLE;
                    end else if (probe_nx == home_q) begin
                        done    <= 1'b1;
                        status  <= (req_op == OP_INSERT) ? ST_FULL : ST_MISS;
                        ctx_out <= 32'd0;
                        state   <= S_IDLE;
                    end else begin
                        probe_q <= probe_nx;
                        state   <= S_READ;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R8: completion is a single-cycle pulse.
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: the engine is idle in the completion cycle.
    a_r8_idle_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8: a start while busy never disturbs the request in flight.
    a_r8_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(req_handle));

    // R7: table-full is only ever reported for an insert.
    a_r7_full_only_insert: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == ST_FULL) |-> (req_op == OP_INSERT));

    // R4: a lookup hit returns a word that is occupied under its mode.
    a_r4_hit_occupied: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == ST_OK && req_op == OP_LOOKUP) |->
        (req_legacy ? ctx_out[31] : (ctx_out != 32'd0)));
endmodule

// File: rtl/obj_hash_engine.sv
// Module: obj_hash_engine (top)
// Handle-to-context hash table engine: folds the request handle into a
// home slot, then the controller probes the internal table RAM.
// Assumes: one request at a time; requests while busy are dropped.
module obj_hash_engine #(
    parameter int SLOT_BITS = 6,
    parameter int CHAN_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic              legacy_mode,
    input  logic [31:0]       handle,
    input  logic [CHAN_W-1:0] chan,
    input  logic [31:0]       ctx_in,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status,
    output logic [31:0]       ctx_out
);
    logic [SLOT_BITS-1:0] home_slot;
    logic                 ram_we;
    logic [SLOT_BITS-1:0] ram_waddr;
    logic [63:0]          ram_wdata;
    logic                 ram_re;
    logic [SLOT_BITS-1:0] ram_raddr;
    logic [63:0]          ram_rdata;

    obj_hash_fold #(.SLOT_BITS(SLOT_BITS), .CHAN_W(CHAN_W)) fold_i (
        .handle (handle),
        .chan   (chan),
        .legacy (legacy_mode),
        .slot   (home_slot)
    );

    obj_hash_ram #(.ADDR_W(SLOT_BITS), .DATA_W(64)) ram_i (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .re    (ram_re),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    obj_hash_ctrl #(.SLOT_BITS(SLOT_BITS)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .op          (op),
        .legacy_mode (legacy_mode),
        .handle      (handle),
        .ctx_in      (ctx_in),
        .home_slot   (home_slot),
        .ram_we      (ram_we),
        .ram_waddr   (ram_waddr),
        .ram_wdata   (ram_wdata),
        .ram_re      (ram_re),
        .ram_raddr   (ram_raddr),
        .ram_rdata   (ram_rdata),
        .busy        (busy),
        .done        (done),
        .status      (status),
        .ctx_out     (ctx_out)
    );
endmodule

// File: tb/obj_hash_engine_tb_top.sv
// Bench for obj_hash_engine: behavioural table model (arrays and integer
// probe loop) predicts status, context and latency; busy is checked on
// every clock of every operation.
module obj_hash_engine_tb_top;
    localparam int B = 6;
    localparam int N = 1 << B;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    op = 2'd0;
    logic          legacy_mode = 1'b1;
    logic [31:0]   handle = '0;
    logic [CW-1:0] chan = '0;
    logic [31:0]   ctx_in = '0;
    logic          busy, done;
    logic [1:0]    status;
    logic [31:0]   ctx_out;

    int checks = 0;
    int errors = 0;

    logic [31:0] mh [N];
    logic [31:0] mc [N];

    always #5 clk = ~clk;

    obj_hash_engine #(.SLOT_BITS(B), .CHAN_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .legacy_mode(legacy_mode), .handle(handle), .chan(chan),
        .ctx_in(ctx_in), .busy(busy), .done(done), .status(status),
        .ctx_out(ctx_out)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int home_of(input logic [31:0] h, input int ch, input bit leg);
        int hs = 0;
        logic [31:0] x = h;
        for (int i = 32; i > 0; i -= B) begin
            hs ^= int'(x & 32'(N - 1));
            x = x >> B;
        end
        if (leg) hs ^= ch << (B - 4);
        return hs & (N - 1);
    endfunction

    function automatic bit is_occ(input logic [31:0] c, input bit leg);
        return leg ? c[31] : (c != 0);
    endfunction

    // Model one operation; updates the model table.
    task automatic model(input int o, input logic [31:0] h, input int ch, input logic [31:0] c,
                         input bit leg, output int st, output logic [31:0] rc, output int k);
        int p = home_of(h, ch, leg);
        st = 1; rc = 0; k = 0;
        for (int n = 0; n < N; n++) begin
            bit occ = is_occ(mc[p], leg);
            k++;
            if (o == 1 && !occ) begin mh[p] = h; mc[p] = c; st = 0; return; end
            if (o != 1 && occ && mh[p] == h) begin
                st = 0;
                if (o == 0) rc = mc[p];
                else begin mh[p] = 0; mc[p] = 0; end
                return;
            end
            p = (p + 1) % N;
        end
        st = (o == 1) ? 2 : 1;
    endtask

    task automatic do_reset(input string req);
        @(negedge clk); rst_n = 1'b0; start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) begin mh[i] = 0; mc[i] = 0; end
        repeat (N - 1) @(posedge clk);
        @(negedge clk);
        chk(busy == 1'b1, {req, " busy during clear"}, busy, 1);
        @(posedge clk); @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, {req, " idle after clear"}, busy, 0);
    endtask

    task automatic run_op(input int o, input logic [31:0] h, input int ch, input logic [31:0] c,
                          input bit leg, input bit poke, input string req);
        int st, k, edges;
        logic [31:0] rc;
        bit busy_ok = 1'b1;
        model(o, h, ch, c, leg, st, rc, k);
        @(negedge clk);
        start = 1'b1; op = 2'(o); handle = h; chan = CW'(ch); ctx_in = c; legacy_mode = leg;
        @(posedge clk);
        @(negedge clk);
        if (poke) begin start = 1'b1; op = 2'd2; handle = ~h; chan = '0; end
        else start = 1'b0;
        edges = 0;
        while (!done && edges < 4 * N + 8) begin
            if (!busy) busy_ok = 1'b0;
            @(posedge clk); edges++;
            @(negedge clk);
        end
        start = 1'b0;
        chk(busy_ok, {req, " busy held (R8)"}, 0, 1);
        chk(edges == 2 * k, {req, " latency (R8)"}, edges, 2 * k);
        chk(status == 2'(st), {req, " status"}, status, st);
        chk(ctx_out == rc, {req, " ctx_out"}, ctx_out, rc);
        chk(busy == 1'b0, {req, " busy low at done (R8)"}, busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: clear sweep, then empty table
        do_reset("R1");
        run_op(0, 32'h1234_5678, 0, 0, 1, 0, "R1 empty lookup");
        run_op(0, 32'hCAFE_0001, 3, 0, 0, 0, "R5 empty lookup new mode");

        // R2/R3: legacy inserts, one probe each when homes distinct
        run_op(1, 32'h0000_0011, 0, 32'h8000_0A01, 1, 0, "R3 insert a");
        run_op(1, 32'hABCD_0123, 2, 32'h8101_0040, 1, 0, "R2 insert b ch2");
        run_op(0, 32'h0000_0011, 0, 0, 1, 0, "R5 lookup a");
        run_op(0, 32'hABCD_0123, 2, 0, 1, 0, "R2 lookup b ch2");
        run_op(0, 32'hABCD_0123, 5, 0, 1, 0, "R2 lookup b other ch");

        // R3: wrap from last slot to slot 0
        run_op(1, 32'h0000_003F, 0, 32'h8000_0003, 1, 0, "R3 insert top slot");
        run_op(1, 32'h0000_007E, 0, 32'h8000_0004, 1, 0, "R3 insert wraps");
        run_op(0, 32'h0000_007E, 0, 0, 1, 0, "R3 lookup wrapped");

        // R6: remove, then lookup of the colliding one still found
        run_op(2, 32'h0000_003F, 0, 0, 1, 0, "R6 remove top");
        run_op(0, 32'h0000_003F, 0, 0, 1, 0, "R6 removed gone");
        run_op(0, 32'h0000_007E, 0, 0, 1, 0, "R6 survivor found");
        run_op(2, 32'hDEAD_BEEF, 1, 0, 1, 0, "R6 remove missing");

        // R4: legacy ignores entries without bit 31; new mode uses non-zero
        run_op(1, 32'h0000_0100, 0, 32'h0000_1234, 1, 0, "R4 insert invalid legacy");
        run_op(0, 32'h0000_0100, 0, 0, 1, 0, "R4 lookup invalid legacy");
        run_op(0, 32'h0000_0100, 0, 0, 0, 0, "R4 lookup same new mode");
        run_op(1, 32'h0000_0200, 7, 32'h0000_0005, 0, 0, "R4 insert new mode");
        run_op(0, 32'h0000_0200, 2, 0, 0, 0, "R2 new mode ignores chan");

        // R8: start while busy is ignored
        run_op(0, 32'h0000_0011, 0, 0, 1, 1, "R8 poke during lookup");
        @(posedge clk); @(negedge clk);
        chk(busy == 1'b0, "R8 no second op accepted", busy, 0);
        run_op(0, ~32'h0000_0011, 0, 0, 1, 0, "R8 poke had no effect");

        // R7: fill the table, then overflow
        do_reset("R1 second");
        for (int i = 0; i < N; i++)
            run_op(1, 32'h0100_0000 + 32'(i * 37), i % 16, 32'h8000_0000 | 32'(i), 1, 0, "R7 fill");
        run_op(1, 32'h7777_7777, 0, 32'h8000_00FF, 1, 0, "R7 insert when full");
        run_op(0, 32'h7777_7777, 0, 0, 1, 0, "R7 full not stored");
        run_op(0, 32'h0100_0000 + 32'(5 * 37), 5, 0, 1, 0, "R5 lookup in full table");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule